// File: doc/BRIEF.md
# Not-Taken Branch Resolution Unit

This block settles equality-compare conditional branches for a short in-order pipeline whose fetch stage always assumes a branch falls through. Fetch therefore keeps reading sequential words, and the only time the program counter is pulled away is when a branch proves to be taken. Each cycle the unit forms both candidate addresses from the current program counter and the sign-extended offset. It tests the two register operands for equality by checking that their bitwise XOR is zero. It then reports whether the branch is taken, which word address to fetch next, and whether the IF/ID register must be cleared.

Since the prediction is always "not taken", every taken branch is a misprediction. On a taken branch the flush and the redirect go out in the same cycle. Two saturating 10-bit performance counters tally branch instructions and taken branches so that software-free profiling can read prediction accuracy off the counter outputs.

Top module: `brp_resolve_unit`

## Requirements
- R1: When the branch is not taken, `next_waddr` equals bits 9..2 of (`cur_pc` + 4) modulo 1024.
- R2: When the branch is taken, `next_waddr` equals bits 9..2 of (`cur_pc` + 4 + `imm_ext[9:0]`) modulo 1024. The offset is a byte offset truncated to 10 bits.
- R3: `br_taken` is 1 exactly when `br_valid` is 1 and `opnd_a` equals `opnd_b` in all 32 bits. It is combinational in the same cycle.
- R4: `flush_ifid` equals `br_taken` in the same cycle. It is 0 whenever `br_valid` is 0, whatever the operands are, including equal operands.
- R5: `cnt_branches` rises by one at each rising clock edge where `br_valid` is 1 and reset is 0. It stays at 1023 once it gets there.
- R6: `cnt_taken` rises by one at each rising clock edge where `br_taken` is 1 and reset is 0. It stays at 1023 once it gets there.
- R7: A synchronous active-high `rst` clears both counters at the next rising edge. It takes priority over any increment in that cycle.
- R8: When `br_valid` is 0, `next_waddr` is the sequential address of R1 even if the operands are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset for the counters |
| br_valid | input | 1 | A conditional equality branch is in the resolve stage |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| cur_pc | input | 10 | Byte address of the branch instruction |
| imm_ext | input | 32 | Sign-extended byte offset |
| br_taken | output | 1 | Branch condition holds |
| flush_ifid | output | 1 | Clear the IF/ID register (misprediction) |
| next_waddr | output | 8 | Word address to fetch next |
| cnt_branches | output | 10 | Saturating count of branch instructions |
| cnt_taken | output | 10 | Saturating count of taken branches |

## Verification
The only state in this block is the pair of counters. A counter that steps wrongly, skips its saturation stop, or ignores reset priority shows up on its output at the very next rising edge. The bench compares both counters against its own model after every edge. A fault in the compare or address path carries no history, so it shows up in the same cycle on `br_taken`, `flush_ifid` or `next_waddr`. Random operand pairs with equality forced half the time, together with PC wrap cases, bring such a fault to the ports within a few dozen cycles.

// File: rtl/brp_pkg.sv
package brp_pkg;
  // Which candidate address the redirect mux selects
  typedef enum logic {
    SEL_SEQ = 1'b0,
    SEL_TGT = 1'b1
  } brp_sel_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/brp_eq_cmp.sv
module brp_eq_cmp #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              equal
);
  localparam int unsigned LANES = (DATA_W + LANE_W - 1) / LANE_W;
  localparam int unsigned PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] diff;
  logic [LANES-1:0] lane_zero;

  // Zero-extended XOR; equality means no bit differs
  always_comb begin
    diff = '0;
    diff[DATA_W-1:0] = lhs ^ rhs;
  end

  // Per-lane zero detect keeps the reduction tree shallow
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_zero[g] = ~|diff[g*LANE_W +: LANE_W];
  end

  assign equal = &lane_zero;
endmodule

// File: rtl/brp_addr_gen.sv
module brp_addr_gen
  import brp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PC_W   = 10
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DATA_W-1:0] offset,
  input  brp_sel_e          sel,
  output logic [PC_W-3:0]   waddr
);
  localparam int unsigned WA_W = PC_W - 2;

  logic [PC_W-1:0] seq_byte;
  logic [PC_W-1:0] tgt_byte;
  logic [PC_W-1:0] pick_byte;

  // Only the low PC_W bits of the offset reach a PC_W-bit sum
  logic unused_offset_hi;
  assign unused_offset_hi = ^offset[DATA_W-1:PC_W];

  assign seq_byte = pc + PC_W'(INSN_BYTES);
  assign tgt_byte = seq_byte + offset[PC_W-1:0];

  always_comb begin
    unique case (sel)
      SEL_TGT: pick_byte = tgt_byte;
      default: pick_byte = seq_byte;
    endcase
  end

  logic unused_byte_lane;
  assign unused_byte_lane = ^pick_byte[1:0];

  assign waddr = pick_byte[PC_W-1 -: WA_W];
endmodule

// File: rtl/brp_sat_counter.sv
module brp_sat_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && (count != CNT_MAX)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/brp_resolve_unit.sv
module brp_resolve_unit
  import brp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PC_W   = 10,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [DATA_W-1:0] imm_ext,
  output logic              br_taken,
  output logic              flush_ifid,
  output logic [PC_W-3:0]   next_waddr,
  output logic [CNT_W-1:0]  cnt_branches,
  output logic [CNT_W-1:0]  cnt_taken
);
  logic     ops_equal;
  brp_sel_e addr_sel;

  brp_eq_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
    .lhs   (opnd_a),
    .rhs   (opnd_b),
    .equal (ops_equal)
  );

  // Predicted not taken: a taken branch is always a misprediction
  assign br_taken   = br_valid & ops_equal;
  assign flush_ifid = br_taken;
  assign addr_sel   = br_taken ? SEL_TGT : SEL_SEQ;

  brp_addr_gen #(.DATA_W(DATA_W), .PC_W(PC_W)) u_addr (
    .pc     (cur_pc),
    .offset (imm_ext),
    .sel    (addr_sel),
    .waddr  (next_waddr)
  );

  brp_sat_counter #(.CNT_W(CNT_W)) u_cnt_seen (
    .clk   (clk),
    .rst   (rst),
    .inc   (br_valid),
    .count (cnt_branches)
  );

  brp_sat_counter #(.CNT_W(CNT_W)) u_cnt_taken (
    .clk   (clk),
    .rst   (rst),
    .inc   (br_taken),
    .count (cnt_taken)
  );
endmodule

// File: rtl/brp_resolve_chk.sv
module brp_resolve_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PC_W   = 10,
  parameter int unsigned CNT_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              br_valid,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [PC_W-1:0]   cur_pc,
  input logic              br_taken,
  input logic              flush_ifid,
  input logic [PC_W-3:0]   next_waddr,
  input logic [CNT_W-1:0]  cnt_branches,
  input logic [CNT_W-1:0]  cnt_taken
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic [PC_W-1:0] seq_b;
  assign seq_b = cur_pc + PC_W'(4);

  AST_TAKEN_NEEDS_EQ: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (br_valid && (opnd_a == opnd_b)));  // R3

  AST_NO_FLUSH_IDLE: assert property (@(posedge clk) disable iff (rst)
    !br_valid |-> !flush_ifid);  // R4

  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (rst)
    !br_taken |-> (next_waddr == seq_b[PC_W-1:2]));  // R1

  AST_SEEN_STEP: assert property (@(posedge clk) disable iff (rst)
    (br_valid && cnt_branches != CMAX) |=> (cnt_branches == $past(cnt_branches) + 1'b1));  // R5

  AST_SEEN_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (cnt_branches == CMAX) |=> (cnt_branches == CMAX));  // R5

  AST_TAKEN_LE_SEEN: assert property (@(posedge clk) disable iff (rst)
    cnt_taken <= cnt_branches);  // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cnt_branches == '0 && cnt_taken == '0));  // R7
endmodule

bind brp_resolve_unit brp_resolve_chk #(
  .DATA_W(DATA_W), .PC_W(PC_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .br_valid     (br_valid),
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b),
  .cur_pc       (cur_pc),
  .br_taken     (br_taken),
  .flush_ifid   (flush_ifid),
  .next_waddr   (next_waddr),
  .cnt_branches (cnt_branches),
  .cnt_taken    (cnt_taken)
);

// File: tb/brp_resolve_unit_tb.sv
module brp_resolve_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_valid = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, imm_ext = '0;
  logic [9:0]  cur_pc = '0;
  logic        br_taken, flush_ifid;
  logic [7:0]  next_waddr;
  logic [9:0]  cnt_branches, cnt_taken;

  int checks = 0, fails = 0;
  int m_seen = 0, m_taken = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  brp_resolve_unit u_dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .cur_pc(cur_pc), .imm_ext(imm_ext), .br_taken(br_taken), .flush_ifid(flush_ifid),
    .next_waddr(next_waddr), .cnt_branches(cnt_branches), .cnt_taken(cnt_taken)
  );

  function automatic logic [7:0] exp_seq(logic [9:0] pc);
    logic [9:0] s = pc + 10'd4;
    return s[9:2];
  endfunction

  function automatic logic [7:0] exp_tgt(logic [9:0] pc, logic [31:0] imm);
    logic [9:0] t = pc + 10'd4 + imm[9:0];
    return t[9:2];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational and counter outputs, then clock
  task automatic step(bit r, bit v, logic [31:0] a, logic [31:0] b, logic [9:0] pc, logic [31:0] imm);
    bit tk;
    @(negedge clk);
    rst = r; br_valid = v; opnd_a = a; opnd_b = b; cur_pc = pc; imm_ext = imm;
    #2;
    tk = v && (a == b);
    chk("R3 taken", br_taken, tk);
    chk("R4 flush", flush_ifid, tk);
    if (tk) chk("R2 target", next_waddr, exp_tgt(pc, imm));
    else if (!v) chk("R8 idle seq", next_waddr, exp_seq(pc));
    else chk("R1 seq", next_waddr, exp_seq(pc));
    chk("R5 seen cnt", cnt_branches, m_seen);
    chk("R6 taken cnt", cnt_taken, m_taken);
    @(posedge clk);
    if (r) begin m_seen = 0; m_taken = 0; end
    else begin
      if (v && m_seen < 1023) m_seen++;
      if (tk && m_taken < 1023) m_taken++;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd1234));
    // Reset state
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 10'h3FC, 0);  // R7 counters zero after reset, R8 wrap
    // Directed: valid equal, wrap of target, negative offset
    step(0, 1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 10'h3F8, 32'h0000_0010);  // R2 wrap
    step(0, 1, 32'h5, 32'h5, 10'h040, 32'hFFFF_FFF0);                  // R2 backward
    step(0, 1, 32'h8000_0000, 32'h0000_0000, 10'h100, 32'h20);          // R1 differ top bit
    step(0, 1, 32'h1, 32'h0, 10'h3FC, 32'h20);                          // R1 wrap
    step(0, 0, 32'h77, 32'h77, 10'h010, 32'h40);                        // R4 R8 equal but idle
    // R7: reset with a taken branch present must win
    step(1, 1, 32'h9, 32'h9, 10'h0, 32'h4);
    step(0, 0, 0, 1, 0, 0);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      a = $urandom;
      b = ($urandom % 2) ? a : (a ^ (32'h1 << ($urandom % 32)));
      step(0, ($urandom % 4) != 0, a, b, 10'($urandom), $urandom);
    end
    // R5 R6 saturation: enough taken branches to pass 1023
    for (int i = 0; i < 1030; i++) step(0, 1, 32'h3, 32'h3, 10'h0, 32'h8);
    step(0, 1, 32'h3, 32'h3, 10'h0, 32'h8);
    step(0, 1, 32'h3, 32'h4, 10'h0, 32'h8);
    // R7 reset clears saturated counters
    step(1, 1, 32'h3, 32'h3, 10'h0, 32'h8);
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule